// File: doc/BRIEF.md
# Comma-aligned bit-serial character framer

The block turns a recovered serial bit stream, one bit per bit clock, into 10-bit characters. Each character comes with a one-cycle strobe. Every bit clock it compares the ten most recently received bits against a framing pattern. When it finds a match, it moves its character boundary so that the next boundary falls at the end of the matched window. The framing-pattern select picks between two patterns: a short comma check on the leading eight bits, or a full check of the 10-bit K28.5 character. Both polarities of the running disparity are accepted in either case.

The block moves the boundary gently so that logic fed by the strobe never sees a sudden phase jump. It lengthens each character period by one or two bit clocks until the accumulated offset has been absorbed, and it never shortens a period. A single detection is enough to start this. A detection that arrives while a move is still under way replaces the remaining offset with one taken from the new match. Holding the enable input low freezes the current boundary, whatever the incoming bits are.

Top module: `comma_framer`

## Requirements
- R1: While rst_ni is low, char_o is 0 and stb_o is 0.
- R2: When no realignment is pending, stb_o pulses exactly once every 10 bit clocks. char_o changes only in a cycle where stb_o is high. char_o holds the last 10 received bits, with the earliest-received bit in bit 9.
- R3: With pat_sel_i = 0, a window matches when its bits 9..2 equal 00111110 or 11000001. Bits 1..0 are ignored.
- R4: With pat_sel_i = 1, only windows of exactly 0011111010 or 1100000101 match. A window that agrees in bits 9..2 but differs in bits 1..0 causes no realignment.
- R5: While frame_en_i is 0, no input pattern changes the boundary, and the strobe interval stays at 10.
- R6: One detection starts realignment. The new boundary is placed immediately after the last bit of the matched window.
- R7: Every strobe interval is 10, 11 or 12 bit clocks. An interval of 12 is used while two or more bits of offset remain. The total stretch equals the boundary offset modulo 10.
- R8: After a match ending at bit p, the seventh following character comes out aligned with its strobe visible p+71 bit clocks after reset release. This lies within nine character periods of the detection.
- R9: A match during an unfinished realignment recomputes the offset from the new match position. The final boundary follows the newest match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Serial data bit, sampled each bit clock |
| frame_en_i | input | 1 | 1 lets a pattern match move the boundary |
| pat_sel_i | input | 1 | 0: 8-bit comma match, 1: full K28.5 match |
| char_o | output | 10 | Framed character, earliest bit in bit 9 |
| stb_o | output | 1 | One-cycle strobe marking a new char_o |

## Verification
The bound checker watches the strobe timing on every cycle. It confirms that intervals never drop below 10 or rise above 12, that char_o moves only with a strobe, and that the interval stays fixed at 10 as long as framing has never been enabled since reset.

Three properties cannot be seen from a single cycle and are shown only by the bench scenarios:
- whether a given window is accepted or rejected under each select setting;
- the exact net stretch after a detection;
- the cycle at which aligned data appears, including the case where a realignment is interrupted by a second match.

// File: rtl/comma_framer_pkg.sv
package comma_framer_pkg;
  localparam int CHAR_W  = 10;
  localparam int COMMA_W = 8;
  typedef logic [CHAR_W-1:0] char_t;
  // negative-disparity K28.5; positive form is its complement
  localparam char_t K_NEG = 10'b0011111010;
endpackage

// File: rtl/cf_shift.sv
module cf_shift
  import comma_framer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_i,
  output char_t win_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_o <= '0;
    else         win_o <= {win_o[CHAR_W-2:0], bit_i};
  end
endmodule

// File: rtl/cf_match.sv
module cf_match
  import comma_framer_pkg::*;
(
  input  char_t win_i,
  input  logic  full_i,
  input  logic  en_i,
  output logic  hit_o
);
  logic [1:0] full_eq, comma_eq;

  for (genvar p = 0; p < 2; p++) begin : g_pol
    localparam char_t PAT = (p == 0) ? K_NEG : ~K_NEG;
    assign full_eq[p]  = (win_i == PAT);
    assign comma_eq[p] = (win_i[CHAR_W-1 -: COMMA_W] == PAT[CHAR_W-1 -: COMMA_W]);
  end

  assign hit_o = en_i & (full_i ? |full_eq : |comma_eq);
endmodule

// File: rtl/cf_align.sv
module cf_align
  import comma_framer_pkg::*;
#(
  parameter int MAX_STRETCH = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hit_i,
  input  char_t win_i,
  output char_t char_o,
  output logic  stb_o
);
  localparam int PW = $clog2(CHAR_W + MAX_STRETCH);
  localparam logic [PW-1:0] LAST = PW'(CHAR_W - 1);
  localparam logic [PW-1:0] MAXS = PW'(MAX_STRETCH);

  logic [PW-1:0] ph_q, lim_q, tgt_q;
  logic [PW-1:0] tgt_eff, lag, ext;
  logic          stb;

  // tgt_q: position inside the target character; LAST marks a target boundary
  assign tgt_eff = hit_i ? LAST : tgt_q;
  assign lag     = LAST - tgt_eff;
  assign ext     = (lag > MAXS) ? MAXS : lag;
  assign stb     = (ph_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      lim_q  <= LAST;
      tgt_q  <= '0;
      stb_o  <= 1'b0;
      char_o <= '0;
    end else begin
      tgt_q <= (tgt_eff == LAST) ? '0 : tgt_eff + 1'b1;
      stb_o <= stb;
      if (stb) begin
        ph_q   <= '0;
        lim_q  <= LAST + ext;
        char_o <= win_i;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/comma_framer.sv
module comma_framer
  import comma_framer_pkg::*;
#(
  parameter int MAX_STRETCH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              frame_en_i,
  input  logic              pat_sel_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              stb_o
);
  char_t win;
  logic  hit;

  cf_shift u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .win_o (win)
  );

  cf_match u_match (
    .win_i (win),
    .full_i(pat_sel_i),
    .en_i  (frame_en_i),
    .hit_o (hit)
  );

  cf_align #(.MAX_STRETCH(MAX_STRETCH)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .win_i (win),
    .char_o(char_o),
    .stb_o (stb_o)
  );
endmodule

// File: rtl/comma_framer_chk.sv
module comma_framer_chk
  import comma_framer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_en_i,
  input logic [CHAR_W-1:0] char_o,
  input logic              stb_o
);
  logic [3:0] gap_q;
  logic       seen_q, en_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      en_seen_q <= 1'b0;
    end else begin
      if (stb_o)              gap_q <= '0;
      else if (gap_q != 4'hf) gap_q <= gap_q + 1'b1;
      if (stb_o)      seen_q    <= 1'b1;
      if (frame_en_i) en_seen_q <= 1'b1;
    end
  end

  AST_PERIOD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= 4'd11); // R7
  AST_PERIOD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o && seen_q |-> gap_q >= 4'd9); // R7
  AST_CHAR_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(char_o) |-> stb_o); // R2
  AST_FROZEN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o && seen_q && !en_seen_q |-> gap_q == 4'd9); // R5
endmodule

bind comma_framer comma_framer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_en_i(frame_en_i),
  .char_o    (char_o),
  .stb_o     (stb_o)
);

// File: tb/comma_framer_bench.sv
module comma_framer_bench;
  localparam int CLK_NS = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       frame_en_i = 1'b0;
  logic       pat_sel_i = 1'b0;
  logic [9:0] char_o;
  logic       stb_o;

  comma_framer u_comma_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (bit_i),
    .frame_en_i(frame_en_i),
    .pat_sel_i (pat_sel_i),
    .char_o    (char_o),
    .stb_o     (stb_o)
  );

  always #(CLK_NS/2) clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  logic [9:0] cap_c [0:63];
  int         cap_t [0:63];
  int         ncap = 0;
  bit         cap_en = 1'b0;
  int         checks = 0;
  int         fails = 0;
  int         nbits = 0;
  int         cyc_rel = 0;

  always @(negedge clk_i) begin
    if (cap_en && stb_o && ncap < 64) begin
      cap_c[ncap] = char_o;
      cap_t[ncap] = cyc;
      ncap++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] dchar(input int k);
    logic [4:0] v;
    logic [9:0] r;
    v = 5'(k + 3);
    for (int i = 0; i < 5; i++) r[9-2*i -: 2] = v[4-i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_i = b;
    nbits++;
  endtask

  task automatic send_char(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic filler(input int n);
    for (int i = 0; i < n; i++) send_bit((i % 2) == 1);
  endtask

  task automatic do_reset(input bit en, input bit sel);
    cap_en = 1'b0;
    rst_ni = 1'b0;
    frame_en_i = en;
    pat_sel_i = sel;
    bit_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(char_o == 10'd0 && stb_o == 1'b0, "R1", "outputs in reset",
          int'({stb_o, char_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bit_i = 1'b0;
    nbits = 1;        // this bit enters on the first edge after release
    cyc_rel = cyc;
    ncap = 0;
    cap_en = 1'b1;
  endtask

  // g2 >= 0: second copy of the pattern after three data chars and g2 filler bits
  task automatic run_case(input bit sel, input bit pol, input int f,
                          input bit en, input bit bad, input int g2);
    logic [9:0] k;
    logic [9:0] cm;
    int pos, extra, n11, bad_iv, exp_extra, iv, j7, tail10;
    bit align, found;
    string req;
    k = pol ? 10'b1100000101 : 10'b0011111010;
    cm = k;
    if (!sel) cm[1:0] = 2'(f);
    if (bad) cm[1:0] = ~k[1:0];
    align = en && !bad;
    req = !en ? "R5" : (bad ? "R4" : (sel ? "R4" : "R3"));

    do_reset(en, sel);
    filler(f);
    send_char(cm);
    pos = nbits;
    if (g2 >= 0) begin
      for (int i = 1; i <= 3; i++) send_char(dchar(i));
      filler(g2);
      send_char(cm);
      pos = nbits;
    end
    for (int i = 1; i <= 12; i++) send_char(dchar(i));
    filler(24);
    cap_en = 1'b0;

    extra = 0; n11 = 0; bad_iv = 0;
    for (int i = 1; i < ncap; i++) begin
      iv = cap_t[i] - cap_t[i-1];
      if (iv < 10 || iv > 12) bad_iv++;
      extra += iv - 10;
      if (iv == 11) n11++;
    end
    check(bad_iv == 0, "R7", "intervals outside 10..12", bad_iv, 0);
    exp_extra = align ? (pos + 1) % 10 : 0;
    if (g2 < 0) begin
      check(extra == exp_extra, align ? "R7" : req, "total stretch", extra, exp_extra);
      check(n11 <= 1, "R7", "count of 11-intervals", n11, 1);
    end else begin
      check((extra % 10) == exp_extra, "R9", "net stretch after restart",
            extra % 10, exp_extra);
    end

    tail10 = 0;
    for (int i = ncap - 3; i < ncap; i++)
      if (cap_t[i] - cap_t[i-1] == 10) tail10++;
    check(tail10 == 3, "R2", "settled interval count", tail10, 3);

    if (align) begin
      found = 1'b0; j7 = -1;
      for (int j = 0; j + 5 < ncap; j++) begin
        if (!found && cap_c[j] == dchar(7)) begin
          found = 1'b1;
          for (int m = 1; m <= 5; m++)
            if (cap_c[j+m] != dchar(7 + m)) found = 1'b0;
          if (found) j7 = j;
        end
      end
      check(found, g2 >= 0 ? "R9" : req, "aligned D7..D12 sequence R6", int'(found), 1);
      if (found)
        check(cap_t[j7] == cyc_rel + pos + 71, "R8", "aligned char timing",
              cap_t[j7] - cyc_rel, pos + 71);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    // R3, R4, R6, R7, R8: both selects, both polarities, all ten offsets
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
        for (int f = 0; f < 10; f++)
          run_case(s[0], p[0], f, 1'b1, 1'b0, -1);
    // R5: framing disabled
    for (int f = 0; f < 10; f++) run_case(1'b0, f[0], f, 1'b0, 1'b0, -1);
    // R4: comma-only window rejected under full-character select
    for (int f = 0; f < 10; f++) run_case(1'b1, f[0], f, 1'b1, 1'b1, -1);
    // R9: second match during or after realignment
    run_case(1'b0, 1'b0, 2, 1'b1, 1'b0, 0);
    run_case(1'b1, 1'b1, 2, 1'b1, 1'b0, 3);
    run_case(1'b0, 1'b1, 5, 1'b1, 1'b0, 5);
    run_case(1'b1, 1'b0, 8, 1'b1, 1'b0, 7);
    finish_run();
  end
endmodule